// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block derives two families of clock outputs from one fast master clock: a group of processor clocks and a group of peripheral-bus clocks. The processor rate is chosen by a select input (divide-by-2 or divide-by-3 of the master clock). The bus clocks run at divide-by-6, so they stay phase-locked to either processor rate. Every output is a registered level that is toggled on master clock edges, and is meant to be treated as a clock enable pattern.

Three active-low controls stop the outputs without glitches: a processor-clock stop, a bus-clock stop and a power-down. Each control passes through a two-flop synchroniser. Gating decisions are taken only at the start of a period of the affected clock, so each period is emitted either whole or not at all. The bus-clock stop is sampled at the rising edge of the free-running bus clock and takes effect one bus period later. The free-running bus clock ignores that stop, but it obeys power-down. After power-down is released, a parameterised settling count runs before the clocks resume with full periods.

Top module: `clkstop_ctrl`

## Requirements
- R1: While reset is asserted, and for at least RESTART_CYCLES master cycles after release, every output is 0.
- R2: With the rate select at 1, each processor output is high for one master cycle in every 2. With it at 0, each processor output is high for one master cycle in every 3.
- R3: The free-running bus output has a period of 6 master cycles and is high for 3 consecutive cycles. Its rising edge comes one master cycle after the processor rising edge that starts the same frame.
- R4: When the processor stop input is 0, the processor outputs stop at a processor period boundary. No pulse is ever cut short, and the outputs stay 0.
- R5: When the processor stop input returns to 1, the processor outputs resume at a period boundary with a full pulse. A processor pulse is never wider than one master cycle.
- R6: The bus-stop input is captured at the rising edge of the free-running bus output. The captured value gates the period that starts at the next rising edge, and a captured 0 holds the gated bus outputs at 0. The free-running output keeps toggling.
- R7: When the power-down input is 0, all outputs, including the free-running one, go to 0 at their next period boundary and stay there.
- R8: After power-down returns to 1, a count of RESTART_CYCLES master cycles runs. The outputs then resume with full periods at the selected rate.
- R9: A change of the rate select takes effect only at the start of a 6-cycle bus frame.
- R10: All processor outputs carry the same waveform, and all gated bus outputs carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_fast_i | input | 1 | Rate select: 1 = divide-by-2, 0 = divide-by-3 |
| cpu_stop_ni | input | 1 | Processor clock stop, active low, asynchronous |
| pci_stop_ni | input | 1 | Gated bus clock stop, active low, asynchronous |
| pwr_down_ni | input | 1 | Power-down, active low, asynchronous |
| cpu_clk_o | output | N_CPU | Processor clock outputs |
| pci_clk_o | output | N_PCI | Gated bus clock outputs |
| pci_free_o | output | 1 | Free-running bus clock output |

## Verification
The hard situations are a stop or release that lands on each of the master-cycle offsets inside a processor period and inside a bus frame. These are where a cut pulse or a one-cycle latency slip would show. The stimulus sweeps the edge of each control across every offset 0 to 5 of the frame, at both processor rates. A cycle-exact behavioural model in the bench predicts every output on every clock. Power-down is also applied while a processor stop is active, and the rate select is flipped in the middle of a frame, to cover the interacting cases.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic {
        MODE_SLOW = 1'b0,
        MODE_FAST = 1'b1
    } cpu_mode_e;

    // Per-cycle frame strobes from the phase counter to the gating logic.
    typedef struct packed {
        logic cpu_edge;   // the next master cycle starts a processor period
        logic pci_edge;   // the next master cycle starts a bus period
        logic pci_high;   // the next master cycle is in the high half of a bus period
    } tick_t;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase
    import clkstop_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 3,
    parameter int PCI_DIV  = 6
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  fast_req_i,
    output tick_t tick_o
);
    localparam int PW       = $clog2(PCI_DIV);
    localparam int PCI_LEAD = 1;
    localparam int PCI_HIGH = PCI_DIV / 2;

    typedef struct packed {
        logic [PW-1:0] ph;
        cpu_mode_e     mode;
    } phase_st_t;

    phase_st_t st_d, st_q;
    cpu_mode_e mode_eff;
    logic      fast_bnd, slow_bnd;

    always_comb begin
        st_d     = st_q;
        mode_eff = (st_q.ph == '0) ? cpu_mode_e'(fast_req_i) : st_q.mode;
        fast_bnd = (int'(st_q.ph) % FAST_DIV) == 0;
        slow_bnd = (int'(st_q.ph) % SLOW_DIV) == 0;

        tick_o.cpu_edge = (mode_eff == MODE_FAST) ? fast_bnd : slow_bnd;
        tick_o.pci_edge = int'(st_q.ph) == PCI_LEAD;
        tick_o.pci_high = (int'(st_q.ph) >= PCI_LEAD) &&
                          (int'(st_q.ph) <  PCI_LEAD + PCI_HIGH);

        st_d.mode = mode_eff;
        st_d.ph   = (int'(st_q.ph) == PCI_DIV - 1) ? '0 : st_q.ph + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{ph: '0, mode: MODE_SLOW};
        else         st_q <= st_d;
    end

    assert_phase_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(st_q.ph) < PCI_DIV);

    assert_mode_switch_at_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode != $past(st_q.mode)) |-> ($past(st_q.ph) == '0));
endmodule

// File: rtl/clkstop_power.sv
module clkstop_power #(
    parameter int RESTART_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic ok_o
);
    localparam int CW = $clog2(RESTART_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } pwr_st_t;

    pwr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
            st_d.ok  = 1'b0;
        end else if (!st_q.ok) begin
            if (int'(st_q.cnt) == RESTART_CYCLES - 1) st_d.ok = 1'b1;
            else                                      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ok_o = st_q.ok;

    assert_pd_drops_ok_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !ok_o);

    assert_ok_after_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ok_o) |-> $past(run_i));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int N_PCI = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  tick_t            tick_i,
    input  logic             cpu_run_i,
    input  logic             pci_run_i,
    input  logic             pwr_ok_i,
    output logic [N_CPU-1:0] cpu_o,
    output logic [N_PCI-1:0] pci_o,
    output logic             free_o
);
    typedef struct packed {
        logic cpu_gate;
        logic pci_cap;
        logic pci_gate;
        logic free_gate;
        logic cpu_out;
        logic pci_out;
        logic free_out;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Gate decisions only at the start of a period: each period is whole or absent.
        if (tick_i.cpu_edge) st_d.cpu_gate = cpu_run_i & pwr_ok_i;
        st_d.cpu_out = tick_i.cpu_edge & st_d.cpu_gate;

        if (tick_i.pci_edge) begin
            st_d.pci_cap   = pci_run_i;
            st_d.pci_gate  = st_q.pci_cap & pwr_ok_i;
            st_d.free_gate = pwr_ok_i;
        end
        st_d.pci_out  = tick_i.pci_high & st_d.pci_gate;
        st_d.free_out = tick_i.pci_high & st_d.free_gate;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu_fan
        assign cpu_o[g] = st_q.cpu_out;
    end
    for (genvar g = 0; g < N_PCI; g++) begin : g_pci_fan
        assign pci_o[g] = st_q.pci_out;
    end
    assign free_o = st_q.free_out;

    assert_cpu_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cpu_out |=> !st_q.cpu_out);

    assert_pci_within_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pci_out |-> st_q.free_out);

    assert_pci_rise_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.pci_out) |-> $rose(st_q.free_out));

    assert_free_full_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.free_out) |=> st_q.free_out ##1 st_q.free_out);

    assert_pd_cpu_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwr_ok_i && tick_i.cpu_edge) |=> !st_q.cpu_out);
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU          = 2,
    parameter int N_PCI          = 5,
    parameter int SYNC_STAGES    = 2,
    parameter int RESTART_CYCLES = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cpu_fast_i,
    input  logic             cpu_stop_ni,
    input  logic             pci_stop_ni,
    input  logic             pwr_down_ni,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o
);
    localparam int NCTL = 4;

    logic [NCTL-1:0] ctl_s;
    tick_t           tick;
    logic            pwr_ok;

    clkstop_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({cpu_fast_i, cpu_stop_ni, pci_stop_ni, pwr_down_ni}),
        .q_o   (ctl_s)
    );

    clkstop_phase #(.FAST_DIV(2), .SLOW_DIV(3), .PCI_DIV(6)) u_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fast_req_i(ctl_s[3]),
        .tick_o    (tick)
    );

    clkstop_power #(.RESTART_CYCLES(RESTART_CYCLES)) u_power (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (ctl_s[0]),
        .ok_o  (pwr_ok)
    );

    clkstop_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_gate (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .cpu_run_i(ctl_s[2]),
        .pci_run_i(ctl_s[1]),
        .pwr_ok_i (pwr_ok),
        .cpu_o    (cpu_clk_o),
        .pci_o    (pci_clk_o),
        .free_o   (pci_free_o)
    );
endmodule

// File: tb/clkstop_ctrl_tb.sv
module clkstop_ctrl_tb;
    localparam int NC = 2;
    localparam int NP = 5;
    localparam int RS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast = 1'b1, cstop_n = 1'b1, pstop_n = 1'b1, pd_n = 1'b1;
    logic [NC-1:0] cpu_clk;
    logic [NP-1:0] pci_clk;
    logic pci_free;

    int n_tests = 0, n_fail = 0, cyc = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    clkstop_ctrl #(.N_CPU(NC), .N_PCI(NP), .SYNC_STAGES(2), .RESTART_CYCLES(RS)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cpu_fast_i(fast), .cpu_stop_ni(cstop_n),
        .pci_stop_ni(pstop_n), .pwr_down_ni(pd_n),
        .cpu_clk_o(cpu_clk), .pci_clk_o(pci_clk), .pci_free_o(pci_free));

    // Behavioural reference: frame position 0..5, each control seen two edges late.
    int ph = 0, cnt = 0;
    bit m_fast = 0, c_on = 0, p_cap = 0, p_on = 0, f_on = 0, ok = 0;
    bit m_cpu = 0, m_pci = 0, m_free = 0;
    bit dly1 [4], dly2 [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; cnt = 0; m_fast = 0; c_on = 0; p_cap = 0; p_on = 0; f_on = 0; ok = 0;
            m_cpu = 0; m_pci = 0; m_free = 0;
            for (int i = 0; i < 4; i++) begin dly1[i] = 0; dly2[i] = 0; end
        end else begin
            bit s_fast, s_c, s_p, s_pd, use_fast, cpu_start;
            int per;
            s_fast = dly2[0]; s_c = dly2[1]; s_p = dly2[2]; s_pd = dly2[3];
            use_fast = (ph == 0) ? s_fast : m_fast;
            per = use_fast ? 2 : 3;
            cpu_start = (ph % per) == 0;
            if (cpu_start) c_on = s_c && ok;
            m_cpu = cpu_start && c_on;
            if (ph == 1) begin
                p_on = p_cap && ok;
                p_cap = s_p;
                f_on = ok;
            end
            m_pci  = (ph >= 1 && ph <= 3) && p_on;
            m_free = (ph >= 1 && ph <= 3) && f_on;
            m_fast = use_fast;
            ph = (ph == 5) ? 0 : ph + 1;
            if (!s_pd) begin cnt = 0; ok = 0; end
            else if (!ok) begin
                if (cnt == RS - 1) ok = 1; else cnt++;
            end
            for (int i = 0; i < 4; i++) dly2[i] = dly1[i];
            dly1[0] = fast; dly1[1] = cstop_n; dly1[2] = pstop_n; dly1[3] = pd_n;
        end
    end

    // Every-clock comparison, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (cpu_clk !== {NC{m_cpu}} || pci_clk !== {NP{m_pci}} || pci_free !== m_free) begin
                n_fail++;
                $display("FAIL %s cycle %0d: cpu=%b pci=%b free=%b expected cpu=%b pci=%b free=%b",
                         tag, cyc, cpu_clk, pci_clk, pci_free,
                         {NC{m_cpu}}, {NP{m_pci}}, m_free);
            end
        end
    end

    task automatic check(input string req, input bit ok_c, input int act, input int exp);
        n_tests++;
        if (!ok_c) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count rising edges of the free output and highs of outputs over n cycles.
    task automatic observe(input int n, output int free_rises, output int cpu_highs,
                           output int pci_highs, output int wide_cpu);
        logic prev_f, prev_c;
        free_rises = 0; cpu_highs = 0; pci_highs = 0; wide_cpu = 0;
        prev_f = pci_free; prev_c = cpu_clk[0];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pci_free && !prev_f) free_rises++;
            if (cpu_clk[0]) cpu_highs++;
            if (cpu_clk[0] && prev_c) wide_cpu++;
            if (|pci_clk) pci_highs++;
            prev_f = pci_free; prev_c = cpu_clk[0];
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int fr, ch, ph_, wc;
        // R1: reset state and settling window
        tag = "R1";
        wait_n(5);
        check("R1 reset cpu", cpu_clk == '0, cpu_clk, 0);
        check("R1 reset pci", pci_clk == '0 && pci_free == 1'b0, pci_clk, 0);
        rst_n = 1'b1;
        observe(RS, fr, ch, ph_, wc);
        check("R1 quiet after release", ch == 0 && ph_ == 0 && fr == 0, ch + ph_ + fr, 0);

        // R2 fast rate, R3 frame shape
        tag = "R2";
        wait_n(12);
        observe(60, fr, ch, ph_, wc);
        check("R2 fast pulses in 60 cycles", ch == 30, ch, 30);
        check("R3 free rises in 60 cycles", fr == 10, fr, 10);
        check("R5 no wide cpu pulse fast", wc == 0, wc, 0);
        // R9: change rate mid-frame
        tag = "R9";
        wait_n(2);
        fast = 1'b0;
        wait_n(12);
        tag = "R2";
        observe(60, fr, ch, ph_, wc);
        check("R2 slow pulses in 60 cycles", ch == 20, ch, 20);
        check("R10 pci copies equal", ph_ == 30, ph_, 30);

        // R4/R5: processor stop swept over all offsets, both rates
        for (int r = 0; r < 2; r++) begin
            fast = r[0];
            for (int off = 0; off < 6; off++) begin
                tag = "R4";
                wait_n(off + 6);
                cstop_n = 1'b0;
                wait_n(8);
                observe(18, fr, ch, ph_, wc);
                check("R4 cpu held low while stopped", ch == 0, ch, 0);
                check("R6 free unaffected by cpu stop", fr == 3, fr, 3);
                tag = "R5";
                cstop_n = 1'b1;
                wait_n(8);
                observe(12, fr, ch, ph_, wc);
                check("R5 cpu resumed", ch == (r ? 6 : 4), ch, r ? 6 : 4);
            end
        end

        // R6: bus stop swept over offsets
        fast = 1'b1;
        for (int off = 0; off < 6; off++) begin
            tag = "R6";
            wait_n(off + 3);
            pstop_n = 1'b0;
            wait_n(16);
            observe(18, fr, ch, ph_, wc);
            check("R6 gated pci low", ph_ == 0, ph_, 0);
            check("R6 free keeps running", fr == 3, fr, 3);
            pstop_n = 1'b1;
            wait_n(20);
        end
        // R6 short pulse between captures
        tag = "R6";
        wait_n(1);
        pstop_n = 1'b0;
        wait_n(2);
        pstop_n = 1'b1;
        wait_n(30);

        // R7/R8: power-down at offsets, also with processor stop active
        for (int off = 0; off < 6; off++) begin
            tag = "R7";
            if (off == 3) cstop_n = 1'b0;
            wait_n(off + 4);
            pd_n = 1'b0;
            wait_n(10);
            observe(18, fr, ch, ph_, wc);
            check("R7 all outputs low", fr == 0 && ch == 0 && ph_ == 0 && pci_free == 0,
                  fr + ch + ph_, 0);
            tag = "R8";
            pd_n = 1'b1;
            cstop_n = 1'b1;
            observe(RS, fr, ch, ph_, wc);
            check("R8 held through settling count", ch == 0 && fr == 0, ch + fr, 0);
            wait_n(14);
            observe(24, fr, ch, ph_, wc);
            check("R8 full-rate resume", ch == 12 && fr == 4 && wc == 0, ch, 12);
        end

        wait_n(4);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule